// File: doc/BRIEF.md
# Wrapping DMA Address Generator

This block produces the byte address for one side of a DMA channel. Software or a channel sequencer loads a start pointer together with a 3-bit wrap code. After that, every accepted transfer pulses the step input, and the address moves forward by one 32-bit word. A wrap code of zero gives a plain linear walk. A non-zero code confines the walk to an aligned window of a power-of-two number of words: the low address bits count modulo the window, and the bits above the window stay fixed at the values in the start pointer.

The `SIDE` parameter picks the wrap table. The memory side (`SIDE` = 0) offers large windows for circular buffers in RAM. The peripheral side (`SIDE` = 1) offers small windows down to a single word, which holds the address on a FIFO data register. A channel uses one instance of each side. The block moves no data and counts no transfers.

Top module: `wrap_addr_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `addrOut` is zero.
- R2: One cycle after `loadEn` is high, `addrOut` equals `loadPtr` with bits [1:0] forced to zero. So `addrOut[1:0]` is always zero. The wrap code applied from then on is the value of `wrapCode` in that same load cycle.
- R3: When `loadEn` and `stepEn` are high in the same cycle, the load wins and the step is discarded.
- R4: With wrap code 0, each step adds 4 to `addrOut`, modulo 2^ADDR_W.
- R5: On the memory side, wrap codes 1 to 7 select windows of 32, 64, 128, 256, 512, 1024 and 2048 words, that is 32·2^(code−1) words. A step increments the address modulo the window, and the address bits above the window hold.
- R6: On the peripheral side, wrap codes 1 to 7 select windows of 1, 2, 4, 8, 16, 32 and 64 words, that is 2^(code−1) words, with the same modulo-increment rule as R5.
- R7: On the peripheral side with wrap code 1, steps leave `addrOut` unchanged at the loaded pointer.
- R8: In a cycle with neither `loadEn` nor `stepEn`, `addrOut` holds its value.
- R9: A change of `wrapCode` without `loadEn` has no effect on later steps.
- R10: The window is the aligned one that contains the start pointer, even when the pointer lies mid-window. After exactly one window's worth of steps, the address returns to the start pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Load `loadPtr` and capture `wrapCode` |
| loadPtr | input | ADDR_W | Start byte address |
| wrapCode | input | 3 | Wrap window code, sampled on load |
| stepEn | input | 1 | Advance by one word |
| addrOut | output | ADDR_W | Current byte address |

## Verification
Both sides are swept through all eight wrap codes. Each run starts from a pointer that sits mid-window and steps a few words past one full window. This separates a correct modulo wrap from a window anchored at the wrong base, from an off-by-one window size, and from a linear walk. Separate patterns check the corner cases. An unaligned pointer shows that the low two bits are dropped. A step in the same cycle as a load shows that the load wins. A code change without a reload shows that the code is latched at load. A linear step from the top of the address space shows the roll-over to zero.

// File: rtl/wag_pkg.sv
package wag_pkg;
  localparam int CODE_W = 3;

  typedef struct packed {
    logic load;
    logic step;
  } wagStrobe_t;
endpackage

// File: rtl/wag_ctrl.sv
module wag_ctrl
  import wag_pkg::*;
#(
  parameter int WORD_W = 30,
  parameter int SIDE   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic              stepEn,
  input  logic [CODE_W-1:0] wrapCode,
  output wagStrobe_t        strobe,
  output logic [WORD_W-1:0] wordMask
);
  logic [CODE_W-1:0] codeReg;
  logic [3:0]        lgWords;

  // Load outranks step (R3)
  assign strobe.load = loadEn;
  assign strobe.step = stepEn & ~loadEn;

  // Wrap code captured only on load (R9)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       codeReg <= '0;
    else if (loadEn) codeReg <= wrapCode;
  end

  generate
    if (SIDE == 0) begin : g_memSide
      // 32 << (code-1) words => log2 = code + 4
      assign lgWords = {1'b0, codeReg} + 4'd4;
    end else begin : g_periSide
      // 1 << (code-1) words => log2 = code - 1
      assign lgWords = {1'b0, codeReg} - 4'd1;
    end
  endgenerate

  always_comb begin
    if (codeReg == '0) wordMask = '1;
    else               wordMask = ~({WORD_W{1'b1}} << lgWords);
  end
endmodule

// File: rtl/wag_datapath.sv
module wag_datapath
  import wag_pkg::*;
#(
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  wagStrobe_t        strobe,
  input  logic [WORD_W-1:0] loadWord,
  input  logic [WORD_W-1:0] wordMask,
  output logic [WORD_W-1:0] wordAddr
);
  logic [WORD_W-1:0] incWord;
  logic [WORD_W-1:0] nextWord;

  assign incWord  = wordAddr + 1'b1;
  assign nextWord = (wordAddr & ~wordMask) | (incWord & wordMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wordAddr <= '0;
    else if (strobe.load) wordAddr <= loadWord;
    else if (strobe.step) wordAddr <= nextWord;
  end
endmodule

// File: rtl/wrap_addr_gen.sv
module wrap_addr_gen
  import wag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIDE   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadPtr,
  input  logic [2:0]        wrapCode,
  input  logic              stepEn,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int WORD_W = ADDR_W - 2;

  wagStrobe_t        strobe;
  logic [WORD_W-1:0] wordMask;
  logic [WORD_W-1:0] wordAddr;

  wag_ctrl #(.WORD_W(WORD_W), .SIDE(SIDE)) ctrlInst (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .stepEn(stepEn),
    .wrapCode(wrapCode), .strobe(strobe), .wordMask(wordMask)
  );

  wag_datapath #(.WORD_W(WORD_W)) dpInst (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .loadWord(loadPtr[ADDR_W-1:2]), .wordMask(wordMask),
    .wordAddr(wordAddr)
  );

  assign addrOut = {wordAddr, 2'b00};
endmodule

// File: rtl/wrap_addr_gen_chk.sv
module wrap_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int SIDE   = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadEn,
  input logic [ADDR_W-1:0] loadPtr,
  input logic [2:0]        wrapCode,
  input logic              stepEn,
  input logic [ADDR_W-1:0] addrOut
);
  logic [2:0]        codeSeen;
  logic [ADDR_W-1:0] hiMask;

  function automatic logic [ADDR_W-1:0] calcHi(input logic [2:0] c);
    int lgBytes;
    lgBytes = (SIDE == 0) ? (int'(c) + 6) : (int'(c) + 1);
    return {ADDR_W{1'b1}} << lgBytes;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeSeen <= '0;
      hiMask   <= '0;
    end else if (loadEn) begin
      codeSeen <= wrapCode;
      hiMask   <= calcHi(wrapCode);
    end
  end

  // R2
  align_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrOut[1:0] == 2'b00);

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> addrOut[ADDR_W-1:2] == $past(loadPtr[ADDR_W-1:2]));

  // R3
  load_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && stepEn) |=> addrOut == {$past(loadPtr[ADDR_W-1:2]), 2'b00});

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !stepEn) |=> $stable(addrOut));

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !loadEn && codeSeen == 3'd0) |=> addrOut == $past(addrOut) + ADDR_W'(4));

  // R5 R6
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !loadEn && codeSeen != 3'd0) |=> (addrOut & hiMask) == $past(addrOut & hiMask));
endmodule

bind wrap_addr_gen wrap_addr_gen_chk #(.ADDR_W(ADDR_W), .SIDE(SIDE)) chkInst (
  .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadPtr(loadPtr),
  .wrapCode(wrapCode), .stepEn(stepEn), .addrOut(addrOut)
);

// File: tb/wrap_addr_gen_test.sv
module wrap_addr_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] loadEn, stepEn;
  logic [ADDR_W-1:0] loadPtr [2];
  logic [2:0] wrapCode [2];
  logic [ADDR_W-1:0] addrOut [2];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrap_addr_gen #(.ADDR_W(ADDR_W), .SIDE(0)) uut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn[0]), .loadPtr(loadPtr[0]),
    .wrapCode(wrapCode[0]), .stepEn(stepEn[0]), .addrOut(addrOut[0]));

  wrap_addr_gen #(.ADDR_W(ADDR_W), .SIDE(1)) uutPeri (
    .clk(clk), .rstN(rstN), .loadEn(loadEn[1]), .loadPtr(loadPtr[1]),
    .wrapCode(wrapCode[1]), .stepEn(stepEn[1]), .addrOut(addrOut[1]));

  task automatic check(input string req, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int winWords(input int side, input int code);
    if (code == 0) return 0;
    return (side == 0) ? (32 << (code - 1)) : (1 << (code - 1));
  endfunction

  function automatic logic [ADDR_W-1:0] model(input int side, input int code,
                                              input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] m;
    if (code == 0) return a + 32'd4;
    m = ADDR_W'(winWords(side, code) * 4 - 1);
    return (a & ~m) | ((a + 32'd4) & m);
  endfunction

  task automatic op(input int side, input bit ld, input bit st,
                    input logic [ADDR_W-1:0] ptr, input logic [2:0] code);
    @(negedge clk);
    loadEn[side] = ld; stepEn[side] = st;
    loadPtr[side] = ptr; wrapCode[side] = code;
    @(negedge clk);
    loadEn[side] = 1'b0; stepEn[side] = 1'b0;
  endtask

  initial begin
    loadEn = '0; stepEn = '0;
    for (int s = 0; s < 2; s++) begin loadPtr[s] = '0; wrapCode[s] = '0; end
    repeat (3) @(negedge clk);
    check("R1 mem reset", addrOut[0], '0);
    check("R1 peri reset", addrOut[1], '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 mem after release", addrOut[0], '0);
    check("R1 peri after release", addrOut[1], '0);

    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 8; c++) begin
        logic [ADDR_W-1:0] start, exp;
        int n;
        string tag;
        start = 32'h5A00_0374 ^ (32'(c) << 6) ^ (32'(s) << 3);
        op(s, 1, 0, start, 3'(c));
        check("R2 load", addrOut[s], start);
        op(s, 0, 0, '0, 3'(c ^ 1));
        check("R8 idle hold", addrOut[s], start);
        n = (c == 0) ? 40 : winWords(s, c) + 3;
        tag = (c == 0) ? "R4 linear" : ((s == 0) ? "R5 mem window" :
              ((c == 1) ? "R7 fixed word" : "R6 peri window"));
        exp = start;
        for (int k = 1; k <= n; k++) begin
          op(s, 0, 1, '0, 3'(7 - c));
          exp = model(s, c, exp);
          check(tag, addrOut[s], exp);
          if (c != 0 && k == winWords(s, c))
            check("R10 back to start", addrOut[s], start);
        end
      end
    end

    op(0, 1, 0, 32'h1234_5677, 3'd0);
    check("R2 low bits dropped", addrOut[0], 32'h1234_5674);
    op(0, 1, 1, 32'h0000_8000, 3'd2);
    check("R3 load beats step", addrOut[0], 32'h0000_8000);
    op(0, 0, 1, '0, 3'd0);
    check("R3 code from that load", addrOut[0], 32'h0000_8004);

    op(1, 1, 0, 32'h4000_0010, 3'd1);
    op(1, 0, 1, '0, 3'd0);
    op(1, 0, 1, '0, 3'd0);
    check("R9 code ignored without load", addrOut[1], 32'h4000_0010);

    op(0, 1, 0, 32'hFFFF_FFFC, 3'd0);
    op(0, 0, 1, '0, 3'd0);
    check("R4 roll over", addrOut[0], 32'h0000_0000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule